// File: doc/BRIEF.md
# Address-Compare Trace Trigger Unit

This block sits beside a processor's program-address and data bus and decides which bus cycles end up in a small trace store. Two programmable address comparators, A and B, feed a single selectable trigger condition. The condition can pair the comparators as an ordered sequence, as either/or, as an inclusive window or its complement, or pair comparator A with a compare on the data byte. Each trigger pulse either opens capture (trace from the trigger onward) or closes it (trace up to and including the trigger). A separate mode with no trigger records every qualified cycle from reset.

Captured addresses go into an eight-entry FIFO that exposes its fill count, its oldest entry and a pop strobe. When the FIFO is full it either drops new entries or overwrites the oldest. A loop option skips an address equal to the one stored just before it, so that tight polling loops do not flood the store. Break requests can be raised on a trigger or when the store fills. Software programs the unit through a small write port that selects one of five registers.

Top module: `trace_trigger_unit`

## Requirements
- R1: After a synchronous reset, `trig_hit`, `fifo_push`, `brk_req` and `fifo_full` are 0 and `fifo_count` is 0. The mode register resets to 0 and the control register resets to 0.
- R2: Register selects are 0 for A, 1 for B, 2 for the data compare value (low 8 bits), 3 for the mode (low 3 bits) and 4 for control (low 6 bits). In mode 1 (either), `trig_hit` is high in the cycle after any qualified bus cycle whose address equals A or B, and it is low after any other cycle.
- R3: In mode 2 (sequence), a B match raises `trig_hit` only if an A match happened in an earlier cycle since reset. After that, every further B match fires.
- R4: Mode 3 fires when A <= address <= B. Mode 4 fires when the address < A or the address > B.
- R5: Mode 5 fires on an access to A whose data byte equals the compare value. Mode 6 fires on an access to A whose data byte differs from it.
- R6: With control bit 5 clear, only cycles with `bus_exec` high count for matching and capture. With bit 5 set, every valid bus cycle counts.
- R7: With control bit 3 clear, capture starts at the trigger cycle, which is stored, and then continues; `fifo_push` follows `trig_hit` by one cycle. In mode 0, every qualified cycle is captured from reset.
- R8: With control bit 3 set, cycles are captured up to and including the trigger cycle and none after it.
- R9: With control bit 0 set, an address equal to the most recently stored address is not stored.
- R10: With control bit 1 clear, pushes into a full FIFO are dropped. With bit 1 set (and bit 2 clear), a push into a full FIFO discards the oldest entry and the count stays at 8.
- R11: With control bit 2 set, `brk_req` goes high in the same cycle the count reaches 8, and no entry is overwritten afterward.
- R12: With control bit 4 set, `brk_req` goes high one cycle after `trig_hit`. `brk_req` stays high until reset.
- R13: `fifo_pop` removes the entry shown on `fifo_head` when the count is not zero. A push and a pop in the same cycle on a full FIFO keep the count at 8 and store the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle strobe |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Data byte of the cycle |
| bus_exec | input | 1 | Opcode at this address is executed |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| fifo_pop | input | 1 | Remove the oldest entry |
| trig_hit | output | 1 | Trigger condition met by the previous bus cycle |
| fifo_push | output | 1 | An entry was stored in the last cycle |
| fifo_addr | output | AW | Address of the last stored entry |
| fifo_head | output | AW | Oldest stored entry |
| fifo_count | output | CW | Number of stored entries |
| fifo_full | output | 1 | Count equals depth |
| brk_req | output | 1 | Sticky break request |

## Verification
A pop and a capture push can land on the same clock edge while the FIFO is full. A push of this kind would be dropped if it came alone. The bench fills the store, then raises `fifo_pop` in the cycle between the bus cycle and its store edge. It then checks three things: the count stays at 8, the head moves to the second entry, and a later lone pop lowers the count. The trigger pulse and the capture decision for the same address also meet in one cycle. Stop and start captures are judged on whether that very address is stored.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [2:0] {
    TM_NONE    = 3'd0,
    TM_EITHER  = 3'd1,
    TM_SEQ     = 3'd2,
    TM_INSIDE  = 3'd3,
    TM_OUTSIDE = 3'd4,
    TM_DATA_EQ = 3'd5,
    TM_DATA_NE = 3'd6
  } trig_mode_e;

  // bit 5 down to bit 0
  typedef struct packed {
    logic mem_any;
    logic brk_trig;
    logic stop_on_trig;
    logic brk_full;
    logic overwrite;
    logic loop_en;
  } trig_ctrl_t;

  localparam int CTRL_W = 6;
endpackage

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_exec,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  input  logic [DW-1:0] cmp_val,
  input  trig_mode_e    mode,
  input  logic          mem_any,
  output logic          hit_o,
  output logic          samp_valid_o,
  output logic [AW-1:0] samp_addr_o
);
  logic qual, eq_a, eq_b, armed_q, cond;

  assign qual = bus_valid && (mem_any || bus_exec);
  assign eq_a = qual && (bus_addr == cmp_a);
  assign eq_b = qual && (bus_addr == cmp_b);

  always_comb begin
    case (mode)
      TM_EITHER:  cond = eq_a || eq_b;
      TM_SEQ:     cond = eq_b && armed_q;
      TM_INSIDE:  cond = qual && (bus_addr >= cmp_a) && (bus_addr <= cmp_b);
      TM_OUTSIDE: cond = qual && ((bus_addr < cmp_a) || (bus_addr > cmp_b));
      TM_DATA_EQ: cond = eq_a && (bus_data == cmp_val);
      TM_DATA_NE: cond = eq_a && (bus_data != cmp_val);
      default:    cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o        <= 1'b0;
      armed_q      <= 1'b0;
      samp_valid_o <= 1'b0;
      samp_addr_o  <= '0;
    end else begin
      hit_o        <= cond;
      armed_q      <= armed_q || (eq_a && (mode == TM_SEQ));
      samp_valid_o <= qual;
      samp_addr_o  <= bus_addr;
    end
  end

  // R6: a trigger only follows a qualified bus cycle
  a_r6_qualified_hit: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(bus_valid && (mem_any || bus_exec)));
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          samp_valid,
  input  logic [AW-1:0] samp_addr,
  input  logic          cap_all,
  input  logic          loop_en,
  input  logic          stop_on_trig,
  input  logic          brk_trig,
  input  logic          brk_full,
  input  logic          stored,
  input  logic          fill_evt,
  output logic          want,
  output logic          brk
);
  logic started_q, stopped_q, last_vld_q, window, dup;
  logic [AW-1:0] last_q;

  assign window = cap_all || (stop_on_trig ? !stopped_q : (started_q || hit));
  assign dup    = loop_en && last_vld_q && (samp_addr == last_q);
  assign want   = samp_valid && window && !dup;

  always_ff @(posedge clk) begin
    if (rst) begin
      started_q  <= 1'b0;
      stopped_q  <= 1'b0;
      last_vld_q <= 1'b0;
      last_q     <= '0;
      brk        <= 1'b0;
    end else begin
      started_q <= started_q || hit;
      stopped_q <= stopped_q || hit;
      if (stored) begin
        last_q     <= samp_addr;
        last_vld_q <= 1'b1;
      end
      brk <= brk || (hit && brk_trig) || (fill_evt && brk_full);
    end
  end

  // R12: break request holds once raised
  a_r12_brk_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(brk) |-> brk);
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic          ovw,
  input  logic          pop,
  output logic          accept,
  output logic          fill_evt,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [AW-1:0] head,
  output logic          push_q,
  output logic [AW-1:0] push_addr_q
);
  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_nx;
  logic pop_ok, drop_old;

  assign full     = (count == CW'(DEPTH));
  assign pop_ok   = pop && (count != '0);
  assign accept   = wr_req && (!full || pop_ok || ovw);
  assign drop_old = accept && full && !pop_ok;
  assign fill_evt = !full && (cnt_nx == CW'(DEPTH));
  assign head     = mem[rd_ptr];

  always_comb begin
    cnt_nx = count;
    if (accept && !drop_old) cnt_nx = cnt_nx + CW'(1);
    if (pop_ok)              cnt_nx = cnt_nx - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wr_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      push_q      <= 1'b0;
      push_addr_q <= '0;
    end else begin
      if (accept) wr_ptr <= wr_ptr + PW'(1);
      if (pop_ok || drop_old) rd_ptr <= rd_ptr + PW'(1);
      count  <= cnt_nx;
      push_q <= accept;
      if (accept) push_addr_q <= wr_addr;
    end
  end

  // R10: the fill count never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R10: overwriting a full store leaves it full
  a_r10_ovw_stays_full: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && ovw && !pop) |=> full);
endmodule

// File: rtl/trace_trigger_unit.sv
module trace_trigger_unit
  import trig_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_exec,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          fifo_pop,
  output logic          trig_hit,
  output logic          fifo_push,
  output logic [AW-1:0] fifo_addr,
  output logic [AW-1:0] fifo_head,
  output logic [CW-1:0] fifo_count,
  output logic          fifo_full,
  output logic          brk_req
);
  logic [AW-1:0] reg_a, reg_b;
  logic [DW-1:0] reg_cmp;
  trig_mode_e    reg_mode;
  trig_ctrl_t    reg_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a    <= '0;
      reg_b    <= '0;
      reg_cmp  <= '0;
      reg_mode <= TM_NONE;
      reg_ctrl <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0:    reg_a    <= cfg_wdata;
        3'd1:    reg_b    <= cfg_wdata;
        3'd2:    reg_cmp  <= cfg_wdata[DW-1:0];
        3'd3:    reg_mode <= trig_mode_e'(cfg_wdata[2:0]);
        3'd4:    reg_ctrl <= trig_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  logic          s_valid, want, accept, fill_evt;
  logic [AW-1:0] s_addr;

  trig_match #(.AW(AW), .DW(DW)) u_match (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_exec(bus_exec),
    .cmp_a(reg_a), .cmp_b(reg_b), .cmp_val(reg_cmp),
    .mode(reg_mode), .mem_any(reg_ctrl.mem_any),
    .hit_o(trig_hit), .samp_valid_o(s_valid), .samp_addr_o(s_addr)
  );

  trig_capture #(.AW(AW)) u_cap (
    .clk(clk), .rst(rst),
    .hit(trig_hit), .samp_valid(s_valid), .samp_addr(s_addr),
    .cap_all(reg_mode == TM_NONE), .loop_en(reg_ctrl.loop_en),
    .stop_on_trig(reg_ctrl.stop_on_trig), .brk_trig(reg_ctrl.brk_trig),
    .brk_full(reg_ctrl.brk_full), .stored(accept), .fill_evt(fill_evt),
    .want(want), .brk(brk_req)
  );

  trace_fifo #(.AW(AW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_req(want), .wr_addr(s_addr),
    .ovw(reg_ctrl.overwrite && !reg_ctrl.brk_full), .pop(fifo_pop),
    .accept(accept), .fill_evt(fill_evt),
    .count(fifo_count), .full(fifo_full), .head(fifo_head),
    .push_q(fifo_push), .push_addr_q(fifo_addr)
  );

  // R9: consecutive stores never repeat an address while loop mode holds
  a_r9_loop_no_dup: assert property (@(posedge clk) disable iff (rst)
    (fifo_push && $past(fifo_push) && reg_ctrl.loop_en && $past(reg_ctrl.loop_en))
      |-> (fifo_addr != $past(fifo_addr)));
endmodule

// File: tb/tb_trace_trigger_unit.sv
`timescale 1ns/1ps
module tb_trace_trigger_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_exec = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fifo_pop = 1'b0;
  logic        trig_hit, fifo_push, fifo_full, brk_req;
  logic [15:0] fifo_addr, fifo_head;
  logic [3:0]  fifo_count;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  trace_trigger_unit dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_exec(bus_exec), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .fifo_pop(fifo_pop), .trig_hit(trig_hit),
    .fifo_push(fifo_push), .fifo_addr(fifo_addr), .fifo_head(fifo_head),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .brk_req(brk_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic e);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_exec = e;
    @(negedge clk);
    bus_valid = 1'b0; bus_exec = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop1();
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 trig_hit", trig_hit, 0);
    chk("R1 fifo_push", fifo_push, 0);
    chk("R1 brk_req", brk_req, 0);
    chk("R1 fifo_full", fifo_full, 0);
    chk("R1 fifo_count", fifo_count, 0);
  endtask

  task automatic t_either();
    do_reset();
    wr(0, 16'h0100); wr(1, 16'h0200); wr(4, 16'h0020); wr(3, 16'd1);
    bus(16'h0150, 0, 0); chk("R2 no match", trig_hit, 0);
    bus(16'h0200, 0, 0); chk("R2 B match", trig_hit, 1);
    bus(16'h0100, 0, 0); chk("R2 A match", trig_hit, 1);
    tick(1);
    chk("R7 start count", fifo_count, 2);
  endtask

  task automatic t_seq();
    do_reset();
    wr(0, 16'h0010); wr(1, 16'h0020); wr(4, 16'h0020); wr(3, 16'd2);
    bus(16'h0020, 0, 0); chk("R3 B before A", trig_hit, 0);
    bus(16'h0010, 0, 0); chk("R3 A arms", trig_hit, 0);
    bus(16'h0030, 0, 0);
    bus(16'h0020, 0, 0); chk("R3 B after A", trig_hit, 1);
    bus(16'h0020, 0, 0); chk("R3 still armed", trig_hit, 1);
  endtask

  task automatic t_range();
    do_reset();
    wr(0, 16'h0040); wr(1, 16'h0060); wr(4, 16'h0020); wr(3, 16'd3);
    bus(16'h003F, 0, 0); chk("R4 in below", trig_hit, 0);
    bus(16'h0040, 0, 0); chk("R4 in low edge", trig_hit, 1);
    bus(16'h0060, 0, 0); chk("R4 in high edge", trig_hit, 1);
    bus(16'h0061, 0, 0); chk("R4 in above", trig_hit, 0);
    wr(3, 16'd4);
    bus(16'h003F, 0, 0); chk("R4 out below", trig_hit, 1);
    bus(16'h0050, 0, 0); chk("R4 out middle", trig_hit, 0);
    bus(16'h0060, 0, 0); chk("R4 out edge", trig_hit, 0);
    bus(16'h0061, 0, 0); chk("R4 out above", trig_hit, 1);
  endtask

  task automatic t_data();
    do_reset();
    wr(0, 16'h0080); wr(1, 16'hFFFF); wr(2, 16'h00A5); wr(4, 16'h0020); wr(3, 16'd5);
    bus(16'h0080, 8'h5A, 0); chk("R5 eq differs", trig_hit, 0);
    bus(16'h0080, 8'hA5, 0); chk("R5 eq equal", trig_hit, 1);
    bus(16'h0081, 8'hA5, 0); chk("R5 eq wrong addr", trig_hit, 0);
    wr(3, 16'd6);
    bus(16'h0080, 8'h5A, 0); chk("R5 ne differs", trig_hit, 1);
    bus(16'h0080, 8'hA5, 0); chk("R5 ne equal", trig_hit, 0);
  endtask

  task automatic t_exec();
    do_reset();
    wr(0, 16'h0100); wr(1, 16'hFFFF); wr(3, 16'd1);
    bus(16'h0100, 0, 0); chk("R6 not executed", trig_hit, 0);
    bus(16'h0100, 0, 1); chk("R6 executed", trig_hit, 1);
    tick(1);
    chk("R6 only executed stored", fifo_count, 1);
  endtask

  task automatic t_start();
    do_reset();
    wr(0, 16'h0300); wr(1, 16'hFFFF); wr(4, 16'h0020); wr(3, 16'd1);
    bus(16'h0001, 0, 0); bus(16'h0002, 0, 0);
    bus(16'h0300, 0, 0);
    chk("R7 hit", trig_hit, 1);
    chk("R7 no push yet", fifo_push, 0);
    bus(16'h0004, 0, 0);
    chk("R7 push after hit", fifo_push, 1);
    chk("R7 push addr", fifo_addr, 16'h0300);
    tick(1);
    chk("R7 count", fifo_count, 2);
    chk("R7 head trigger", fifo_head, 16'h0300);
    pop1();
    chk("R13 head after pop", fifo_head, 16'h0004);
    do_reset();
    wr(4, 16'h0020);
    bus(16'h0005, 0, 0); tick(1);
    chk("R7 mode0 capture", fifo_count, 1);
  endtask

  task automatic t_stop();
    do_reset();
    wr(0, 16'h0500); wr(1, 16'hFFFF); wr(4, 16'h0028); wr(3, 16'd1);
    bus(16'h0001, 0, 0); bus(16'h0002, 0, 0); bus(16'h0500, 0, 0); bus(16'h0003, 0, 0);
    tick(2);
    chk("R8 count", fifo_count, 3);
    chk("R8 head", fifo_head, 16'h0001);
    pop1(); pop1();
    chk("R8 last is trigger", fifo_head, 16'h0500);
  endtask

  task automatic t_loop();
    do_reset();
    wr(4, 16'h0021);
    bus(16'h0007, 0, 0); bus(16'h0007, 0, 0); bus(16'h0007, 0, 0);
    bus(16'h0008, 0, 0); bus(16'h0007, 0, 0);
    tick(2);
    chk("R9 count", fifo_count, 3);
  endtask

  task automatic t_full();
    do_reset();
    wr(4, 16'h0020);
    for (int i = 0; i < 10; i++) bus(16'h0020 + 16'(i), 0, 0);
    tick(2);
    chk("R10 drop count", fifo_count, 8);
    chk("R10 drop full", fifo_full, 1);
    chk("R10 drop head", fifo_head, 16'h0020);
    do_reset();
    wr(4, 16'h0022);
    for (int i = 0; i < 10; i++) bus(16'h0020 + 16'(i), 0, 0);
    tick(2);
    chk("R10 ovw count", fifo_count, 8);
    chk("R10 ovw head", fifo_head, 16'h0022);
  endtask

  task automatic t_brkfull();
    do_reset();
    wr(4, 16'h0026);
    for (int i = 0; i < 7; i++) bus(16'h0040 + 16'(i), 0, 0);
    tick(1);
    chk("R11 no brk at 7", brk_req, 0);
    bus(16'h0047, 0, 0); tick(1);
    chk("R11 brk at fill", brk_req, 1);
    chk("R11 count 8", fifo_count, 8);
    bus(16'h0048, 0, 0); tick(1);
    chk("R11 no overwrite", fifo_head, 16'h0040);
    chk("R12 brk sticky", brk_req, 1);
  endtask

  task automatic t_brktrig();
    do_reset();
    wr(0, 16'h0077); wr(1, 16'hFFFF); wr(4, 16'h0030); wr(3, 16'd1);
    bus(16'h0077, 0, 0);
    chk("R12 hit", trig_hit, 1);
    chk("R12 brk not yet", brk_req, 0);
    tick(1);
    chk("R12 brk after hit", brk_req, 1);
  endtask

  task automatic t_pushpop();
    do_reset();
    wr(4, 16'h0020);
    for (int i = 0; i < 8; i++) bus(16'h0010 + 16'(i), 0, 0);
    tick(2);
    chk("R13 filled", fifo_count, 8);
    bus_valid = 1'b1; bus_addr = 16'h0018;
    @(negedge clk);
    bus_valid = 1'b0; fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
    chk("R13 same-cycle count", fifo_count, 8);
    chk("R13 same-cycle head", fifo_head, 16'h0011);
    chk("R13 same-cycle push", fifo_push, 1);
    pop1();
    chk("R13 lone pop", fifo_count, 7);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_either();
    t_seq();
    t_range();
    t_data();
    t_exec();
    t_start();
    t_stop();
    t_loop();
    t_full();
    t_brkfull();
    t_brktrig();
    t_pushpop();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule